// File: doc/BRIEF.md
# Interleave-Aware Burst Splitter

This block sits at the entry of an interconnect in front of several memory controllers. Those controllers share one address space, which is cut into equal power-of-two granules. The granules are dealt out to the controllers in rotation, so granule k belongs to controller k mod N.

The block takes one incrementing read or write address request at a time. Each request carries an address, a beat count, a transfer size and an ID. The block cuts the request at every granule edge that it crosses. It then emits the pieces in address order, one per handshake. Each piece carries the controller index that owns its granule, its start address and its own beat count. The final piece is flagged.

The granule size and the controller count are runtime settings. Both are captured when a request is accepted, so a setting can be changed between bursts.

Top module: `ilv_burst_splitter`

## Requirements
- R1: `cfg_gran_sel` value s selects a granule of 64·2^s bytes for s in 0..6. Values 7 and above select 4096 bytes.
- R2: The controller count is 2^`cfg_tgt_log2`, clamped to 2^3. A piece goes to controller (address >> log2 granule) mod count on `out_tgt`.
- R3: No piece covers bytes of two granules. A burst is cut exactly at each granule edge it crosses.
- R4: The beat count of a piece is the smaller of two values: the beats still owed in the burst, and the beats left before the next granule edge. `out_len` is that count minus one, the same encoding as `in_len`.
- R5: Pieces come out in ascending address order. The first piece starts at `in_addr`. Each later piece starts exactly at a granule edge. `out_size` and `out_id` repeat the request's values.
- R6: `out_last` is 1 on the final piece of a burst and 0 on every other piece.
- R7: `in_ready` is 1 when the block is idle. It drops in the cycle after a request is accepted, and `out_valid` rises in that same cycle. `in_ready` rises again in the cycle after the last piece is taken.
- R8: While `out_valid` is high and `out_ready` is low, all piece fields stay unchanged.
- R9: Changes to `cfg_gran_sel` or `cfg_tgt_log2` after a request is accepted do not affect that request's pieces.
- R10: With a 4096-byte granule, any burst that stays within one 4 KB window comes out as a single piece with `out_last` set.
- R11: Successive pieces of one burst go to successive controllers: index + 1, wrapping modulo the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_gran_sel | input | 3 | Granule size select |
| cfg_tgt_log2 | input | 2 | log2 of controller count |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Request accepted when high with in_valid |
| in_addr | input | ADDR_W | Request start byte address |
| in_len | input | LEN_W | Request beats minus one |
| in_size | input | 3 | log2 bytes per beat |
| in_id | input | ID_W | Transaction ID |
| out_valid | output | 1 | Piece valid |
| out_ready | input | 1 | Downstream takes the piece |
| out_addr | output | ADDR_W | Piece start address |
| out_len | output | LEN_W | Piece beats minus one |
| out_size | output | 3 | log2 bytes per beat |
| out_id | output | ID_W | Transaction ID |
| out_tgt | output | TGT_W | Controller index |
| out_last | output | 1 | Final piece of the burst |

## Verification
The assertions take the following for granted about each request:
- it never crosses a 4 KB boundary;
- its beat size in bytes does not exceed the granule;
- its addresses do not wrap past the top of the address space.

Under those conditions, a piece's end address lies inside its granule, and each new piece lands in the next granule. The stimulus meets these conditions as follows. Directed cases are picked by hand. Random cases keep sizes at 64 bytes or less, which is never larger than the smallest granule. They also clamp each beat count so the burst ends before the next 4 KB boundary above its aligned start.

// File: rtl/ilv_pkg.sv
package ilv_pkg;
  localparam int unsigned GRAN_MIN_LOG2 = 6;
  localparam int unsigned GRAN_MAX_LOG2 = 12;
  localparam int unsigned GSEL_MAX      = GRAN_MAX_LOG2 - GRAN_MIN_LOG2;
  localparam int unsigned EDGE_W        = GRAN_MAX_LOG2 + 1;

  // granule select -> log2 of granule bytes, saturating at the largest size
  function automatic logic [3:0] gran_log2_of(input logic [2:0] sel);
    if (sel > 3'(GSEL_MAX)) return 4'(GRAN_MAX_LOG2);
    return 4'(GRAN_MIN_LOG2) + {1'b0, sel};
  endfunction

  // granule number of a byte address
  function automatic logic [63:0] gran_index(input logic [63:0] addr, input logic [3:0] glog2);
    return addr >> glog2;
  endfunction

  // beats of the given size from addr (rounded down to the size) to the next granule edge
  function automatic logic [EDGE_W-1:0] beats_to_edge(input logic [63:0] addr,
                                                      input logic [2:0]  size,
                                                      input logic [3:0]  glog2);
    logic [63:0] span;
    logic [63:0] off;
    span = 64'd1 << glog2;
    off  = addr & (span - 64'd1);
    return EDGE_W'((span >> size) - (off >> size));
  endfunction
endpackage

// File: rtl/ilv_chop_calc.sv
module ilv_chop_calc #(
  parameter int ADDR_W = 32,
  parameter int BEAT_W = 9
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [BEAT_W-1:0] left,
  input  logic [2:0]        size,
  input  logic [3:0]        glog2,
  output logic [BEAT_W-1:0] beats,
  output logic [ADDR_W-1:0] next_addr,
  output logic              last
);
  import ilv_pkg::*;
  localparam int CW = (BEAT_W > int'(EDGE_W)) ? BEAT_W : int'(EDGE_W);

  logic [CW-1:0] span_beats;
  logic [CW-1:0] left_w;

  always_comb begin
    span_beats = CW'(beats_to_edge(64'(addr), size, glog2));
    left_w     = CW'(left);
    last       = (left_w <= span_beats);
    beats      = last ? left : BEAT_W'(span_beats);
    next_addr  = ((addr >> size) << size) + (ADDR_W'(beats) << size);
  end
endmodule

// File: rtl/ilv_tgt_sel.sv
module ilv_tgt_sel #(
  parameter int ADDR_W = 32,
  parameter int TGT_W  = 3,
  parameter int TL_W   = 2
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [3:0]        glog2,
  input  logic [TL_W-1:0]   tlog2,
  output logic [TGT_W-1:0]  tgt
);
  import ilv_pkg::*;
  logic [TGT_W-1:0] gidx_low;

  always_comb gidx_low = TGT_W'(gran_index(64'(addr), glog2));

  // keep only the low tlog2 bits of the granule number: k mod 2^tlog2
  for (genvar i = 0; i < TGT_W; i++) begin : g_mask
    assign tgt[i] = gidx_low[i] & (tlog2 > TL_W'(i));
  end
endmodule

// File: rtl/ilv_burst_splitter.sv
module ilv_burst_splitter #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 8,
  parameter int ID_W   = 4,
  parameter int TGT_W  = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [2:0]                cfg_gran_sel,
  input  logic [$clog2(TGT_W+1)-1:0] cfg_tgt_log2,
  input  logic                      in_valid,
  output logic                      in_ready,
  input  logic [ADDR_W-1:0]         in_addr,
  input  logic [LEN_W-1:0]          in_len,
  input  logic [2:0]                in_size,
  input  logic [ID_W-1:0]           in_id,
  output logic                      out_valid,
  input  logic                      out_ready,
  output logic [ADDR_W-1:0]         out_addr,
  output logic [LEN_W-1:0]          out_len,
  output logic [2:0]                out_size,
  output logic [ID_W-1:0]           out_id,
  output logic [TGT_W-1:0]          out_tgt,
  output logic                      out_last
);
  import ilv_pkg::*;
  localparam int BEAT_W = LEN_W + 1;
  localparam int TL_W   = $clog2(TGT_W + 1);

  logic              busy;
  logic [ADDR_W-1:0] cur_addr;
  logic [BEAT_W-1:0] cur_left;
  logic [2:0]        cur_size;
  logic [ID_W-1:0]   cur_id;
  logic [3:0]        cur_glog2;
  logic [TL_W-1:0]   cur_tlog2;

  // named events for checks
  logic              in_accept;
  logic              out_fire;
  logic [BEAT_W-1:0] sub_beats;
  logic [ADDR_W-1:0] sub_next;
  logic              sub_last;
  logic [TL_W-1:0]   tlog2_clamped;
  logic [TGT_W-1:0]  tgt_mask;

  assign in_ready  = !busy;
  assign in_accept = in_valid && in_ready;
  assign out_fire  = out_valid && out_ready;
  assign tlog2_clamped = (cfg_tgt_log2 > TL_W'(TGT_W)) ? TL_W'(TGT_W) : cfg_tgt_log2;
  assign tgt_mask  = TGT_W'((32'd1 << cur_tlog2) - 32'd1);

  ilv_chop_calc #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_chop (
    .addr(cur_addr), .left(cur_left), .size(cur_size), .glog2(cur_glog2),
    .beats(sub_beats), .next_addr(sub_next), .last(sub_last)
  );

  ilv_tgt_sel #(.ADDR_W(ADDR_W), .TGT_W(TGT_W), .TL_W(TL_W)) u_tgt (
    .addr(cur_addr), .glog2(cur_glog2), .tlog2(cur_tlog2), .tgt(out_tgt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      cur_addr  <= '0;
      cur_left  <= '0;
      cur_size  <= '0;
      cur_id    <= '0;
      cur_glog2 <= 4'(GRAN_MIN_LOG2);
      cur_tlog2 <= '0;
    end else if (in_accept) begin
      busy      <= 1'b1;
      cur_addr  <= in_addr;
      cur_left  <= BEAT_W'(in_len) + BEAT_W'(1);
      cur_size  <= in_size;
      cur_id    <= in_id;
      cur_glog2 <= gran_log2_of(cfg_gran_sel);
      cur_tlog2 <= tlog2_clamped;
    end else if (out_fire) begin
      if (sub_last) begin
        busy <= 1'b0;
      end else begin
        cur_addr <= sub_next;
        cur_left <= cur_left - sub_beats;
      end
    end
  end

  assign out_valid = busy;
  assign out_addr  = cur_addr;
  assign out_len   = LEN_W'(sub_beats - BEAT_W'(1));
  assign out_size  = cur_size;
  assign out_id    = cur_id;
  assign out_last  = sub_last;

  // R3: a piece's last byte lies in the same granule as its first byte
  assert_one_granule_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (((sub_next - ADDR_W'(1)) >> cur_glog2) == (out_addr >> cur_glog2)));

  // R7: no new request is taken while pieces are pending
  assert_input_blocked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  // R7: request acceptance is followed by a valid piece
  assert_valid_after_accept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    in_accept |=> out_valid);

  // R8: stalled piece holds its fields
  assert_hold_when_stalled_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_addr) && $stable(out_len)
                                   && $stable(out_tgt) && $stable(out_last)));

  // R11: next piece of a burst goes to the following controller
  assert_rr_step_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_fire && !out_last) |=> (out_valid && out_tgt == ((TGT_W'($past(out_tgt)) + TGT_W'(1)) & tgt_mask)));

  // R5: pieces climb in address
  assert_ascending_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_fire && !out_last) |=> (out_addr > $past(out_addr)));

  // R6: after the flagged piece is taken the output goes idle
  assert_last_ends_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_fire && out_last) |=> !out_valid);
endmodule

// File: tb/ilv_burst_splitter_test.sv
module ilv_burst_splitter_test;
  typedef struct {
    logic [31:0] addr;
    logic [7:0]  len;
    logic [2:0]  tgt;
    logic        last;
    logic [3:0]  id;
    logic [2:0]  size;
  } sub_t;

  logic        clk = 0;
  logic        rst_n = 0;
  logic [2:0]  cfg_gran_sel = 0;
  logic [1:0]  cfg_tgt_log2 = 0;
  logic        in_valid = 0;
  logic        in_ready;
  logic [31:0] in_addr = 0;
  logic [7:0]  in_len = 0;
  logic [2:0]  in_size = 0;
  logic [3:0]  in_id = 0;
  logic        out_valid;
  logic        out_ready = 1;
  logic [31:0] out_addr;
  logic [7:0]  out_len;
  logic [2:0]  out_size;
  logic [3:0]  out_id;
  logic [2:0]  out_tgt;
  logic        out_last;

  int   checks = 0;
  int   errors = 0;
  bit   done = 0;
  bit   bp_en = 0;
  sub_t expq[$];

  always #4 clk = ~clk;

  ilv_burst_splitter uut (
    .clk(clk), .rst_n(rst_n), .cfg_gran_sel(cfg_gran_sel), .cfg_tgt_log2(cfg_tgt_log2),
    .in_valid(in_valid), .in_ready(in_ready), .in_addr(in_addr), .in_len(in_len),
    .in_size(in_size), .in_id(in_id), .out_valid(out_valid), .out_ready(out_ready),
    .out_addr(out_addr), .out_len(out_len), .out_size(out_size), .out_id(out_id),
    .out_tgt(out_tgt), .out_last(out_last)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // downstream backpressure, changed just after each rising edge
  always @(posedge clk) begin
    #1 out_ready <= bp_en ? (($urandom % 3) != 0) : 1'b1;
  end

  // monitor: pop and compare on each handshake; watch stalls
  initial begin
    bit   held = 0;
    sub_t snap;
    forever begin
      @(negedge clk);
      if (rst_n && !done) begin
        if (held && out_valid) begin
          chk(out_addr == snap.addr && out_len == snap.len && out_tgt == snap.tgt && out_last == snap.last,
              "R8", "stalled piece changed", out_addr, snap.addr);
        end
        held = 0;
        if (out_valid && !out_ready) begin
          held = 1;
          snap.addr = out_addr; snap.len = out_len; snap.tgt = out_tgt; snap.last = out_last;
        end
        if (out_valid && out_ready) begin
          if (expq.size() == 0) begin
            chk(0, "R5", "unexpected piece at", out_addr, 0);
          end else begin
            sub_t e;
            e = expq.pop_front();
            chk(out_addr == e.addr, "R5", "piece address", out_addr, e.addr);
            chk(out_len == e.len, "R4", "piece length", 32'(out_len), 32'(e.len));
            chk(out_tgt == e.tgt, "R2", "target index", 32'(out_tgt), 32'(e.tgt));
            chk(out_last == e.last, "R6", "last flag", 32'(out_last), 32'(e.last));
            chk(out_id == e.id && out_size == e.size, "R5", "id/size echo",
                {out_id, 1'b0, out_size}, {e.id, 1'b0, e.size});
            chk(!in_ready, "R7", "in_ready while busy", 32'(in_ready), 0);
          end
        end
      end
    end
  end

  // driver: computes the expected pieces beat by beat, then sends the request
  task automatic send(input logic [31:0] a, input logic [7:0] len, input logic [2:0] sz,
                      input logic [3:0] id, input bit scramble);
    int          glog2;
    int          ncnt;
    logic [31:0] aligned;
    logic [31:0] ba;
    logic [31:0] g;
    logic [31:0] prevg;
    int          beats;
    sub_t        cur;
    logic [2:0]  keep_g;
    logic [1:0]  keep_t;
    glog2   = (cfg_gran_sel > 6) ? 12 : 6 + int'(cfg_gran_sel);
    ncnt    = 1 << cfg_tgt_log2;
    aligned = a & ~((32'd1 << sz) - 1);
    beats   = 0;
    prevg   = 0;
    for (int i = 0; i <= int'(len); i++) begin
      ba = (i == 0) ? a : aligned + (32'(i) << sz);
      g  = ba >> glog2;
      if (i > 0 && g != prevg) begin
        cur.len = 8'(beats - 1);
        expq.push_back(cur);
        beats = 0;
      end
      if (beats == 0) begin
        cur.addr = ba; cur.tgt = 3'(g % 32'(ncnt)); cur.last = 0; cur.id = id; cur.size = sz;
      end
      beats++;
      prevg = g;
    end
    cur.len  = 8'(beats - 1);
    cur.last = 1;
    expq.push_back(cur);

    keep_g = cfg_gran_sel;
    keep_t = cfg_tgt_log2;
    @(negedge clk);
    in_valid = 1; in_addr = a; in_len = len; in_size = sz; in_id = id;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    #1 in_valid = 0;
    if (scramble) begin
      cfg_gran_sel = keep_g ^ 3'd5;
      cfg_tgt_log2 = keep_t ^ 2'd3;
    end
    @(negedge clk);
    chk(out_valid, "R7", "out_valid one cycle after accept", 32'(out_valid), 1);
    wait (expq.size() == 0);
    @(posedge clk);
    @(negedge clk);
    chk(in_ready && !out_valid, "R7", "ready again after last piece", 32'(in_ready), 1);
    cfg_gran_sel = keep_g;
    cfg_tgt_log2 = keep_t;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!out_valid && in_ready, "R7", "reset state", {out_valid, in_ready}, 2'b01);

    // R2 R3: two controllers, 1 KB granule, 2 KB aligned burst -> two halves
    cfg_gran_sel = 3'd4; cfg_tgt_log2 = 2'd1;
    send(32'h0000_0000, 8'd255, 3'd3, 4'h1, 0);
    // R3 R11: four controllers, 256 B granule, 1 KB burst -> four pieces in turn
    cfg_gran_sel = 3'd2; cfg_tgt_log2 = 2'd2;
    send(32'h0000_1000, 8'd255, 3'd2, 4'h2, 0);
    // R4 R5: unaligned start, 64 B granule, eight controllers
    cfg_gran_sel = 3'd0; cfg_tgt_log2 = 2'd3;
    send(32'h0000_013C, 8'd9, 3'd3, 4'h3, 0);
    // R10: 4 KB granule, whole-window burst stays whole
    cfg_gran_sel = 3'd6; cfg_tgt_log2 = 2'd1;
    send(32'h0000_3000, 8'd255, 3'd4, 4'h4, 0);
    send(32'h0000_2F00, 8'd15, 3'd4, 4'h5, 0);
    // R1: out-of-range select saturates at 4 KB
    cfg_gran_sel = 3'd7;
    send(32'h0000_5000, 8'd127, 3'd5, 4'h6, 0);
    // R2: single controller
    cfg_gran_sel = 3'd1; cfg_tgt_log2 = 2'd0;
    send(32'h0000_0440, 8'd63, 3'd2, 4'h7, 0);
    // R9: settings changed mid-burst must not matter
    cfg_gran_sel = 3'd3; cfg_tgt_log2 = 2'd1;
    send(32'h0000_0800, 8'd127, 3'd3, 4'h8, 1);
    // R8: random traffic with backpressure
    bp_en = 1;
    for (int k = 0; k < 60; k++) begin
      logic [31:0] a;
      logic [2:0]  sz;
      int          maxb;
      cfg_gran_sel = 3'($urandom % 8);
      cfg_tgt_log2 = 2'($urandom % 4);
      sz   = 3'($urandom % 7);
      a    = $urandom & 32'h000F_FFFF;
      maxb = int'((32'd4096 - ((a & 32'hFFF) & ~((32'd1 << sz) - 1))) >> sz);
      if (maxb > 256) maxb = 256;
      send(a, 8'($urandom % maxb), sz, 4'(k), (k % 5) == 0);
    end
    bp_en = 0;
    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule